// File: doc/BRIEF.md
# NAND Syndrome Page Layout De-interleaver

This block sits behind the flash bus engine of a NAND controller. It receives the raw bytes of one physical page, one byte per handshake, and sorts each byte by the role its physical offset gives it in a layout where ECC parity is interleaved with the payload. The layout has two ECC steps. Each step covers a payload chunk and is followed directly by its parity bytes. A bad-block marker sits at the first bytes of the spare area, outside ECC coverage, so the second payload chunk is cut in two around it. The free spare bytes fill the rest of the spare area.

Payload bytes leave in order on a valid/ready byte stream. They come from the first chunk and then from both parts of the second chunk, so the consumer sees a contiguous logical payload. The marker, the two ECC sections and the free bytes are written into a logical out-of-band buffer. This buffer is what a spare-area read hands to software, in place of the physical spare bytes. A transfer-mode input, sampled at start, says whether the incoming stream covers the main area, the spare area or both, and the offset counter starts and stops to match. The geometry is fixed by parameters at elaboration.

Top module: `nand_syn_deint`

## Requirements
- R1: After reset, in_ready, dout_valid, done, partial and err are 0 and every byte of oob_bytes is 0.
- R2: A byte whose physical offset falls in a payload range is presented on dout_data in arrival order, exactly once. The payload ranges are [0, STEP), [STEP+ECC, MAIN) and [MAIN+MARK, 2*STEP+ECC+MARK). No other byte reaches dout_data.
- R3: Non-payload bytes are stored in oob_bytes, with logical byte k at bits [8k+7:8k]. The marker goes to k = 0..MARK-1, ECC0 (offsets STEP..STEP+ECC-1) to the next ECC slots, ECC1 (the ECC bytes after the second payload tail) to the next ECC slots, and the free bytes to the remaining slots.
- R4: xfer_mode 1 (spare only) makes the first accepted byte physical offset MAIN and the last one MAIN+SPARE-1. The payload tail bytes in that range still go to dout_data.
- R5: xfer_mode 0 (main only) accepts exactly MAIN bytes, offsets 0..MAIN-1, and does not wait for spare bytes.
- R6: done is high for exactly the one cycle after the cycle in which the last byte of the selected mode is accepted. From then on in_ready stays 0 until a new start.
- R7: A start while a page is in progress is ignored, and the page continues unchanged. err becomes 1 in the next cycle and stays 1 until a start is accepted while idle, which clears it.
- R8: While dout_valid is 1 and dout_ready is 0, dout_data holds its value. in_ready is 1 exactly when a page is in progress and the output register is empty or being drained.
- R9: Each start accepted while idle clears every byte of oob_bytes to 0 in the next cycle.
- R10: partial becomes 1 with done when the completed page was in mode 0 or 1, and 0 when it was in mode 2 or 3. An accepted start clears it.
- R11: xfer_mode 2 and 3 both cover the whole raw page, offsets 0..MAIN+SPARE-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a page transfer (accepted only while idle) |
| xfer_mode | input | 2 | 0 main only, 1 spare only, 2 or 3 both |
| in_valid | input | 1 | Raw byte valid |
| in_data | input | 8 | Raw byte in physical order |
| in_ready | output | 1 | Raw byte accepted when in_valid is also high |
| dout_valid | output | 1 | Payload byte valid |
| dout_data | output | 8 | Payload byte in logical order |
| dout_ready | input | 1 | Consumer accepts the payload byte |
| oob_bytes | output | OOB_BYTES*8 | Logical out-of-band buffer, byte k at [8k+7:8k] |
| done | output | 1 | One-cycle pulse after the last byte of the page |
| partial | output | 1 | Last completed page did not cover the whole raw page |
| err | output | 1 | Start arrived while a page was in progress |

## Verification
The bench builds the block with a reduced geometry: 32-byte steps, 4 ECC bytes, a 64-byte main area, a 16-byte spare area and a 2-byte marker. This makes a whole page 80 bytes long, so every section boundary is crossed in a handful of cycles. With these values the split of the second chunk around the marker falls 28 bytes before and 4 bytes after it. All section ends, the mode-dependent first and last offsets, and a start that coincides with the last byte can be reached many times over within one short run, under steady, random and long output stalls.

// File: rtl/nand_sl_pkg.sv
package nand_sl_pkg;

    localparam int IDX_W = 16;

    localparam logic [1:0] XFER_MAIN  = 2'd0;
    localparam logic [1:0] XFER_SPARE = 2'd1;
    localparam logic [1:0] XFER_BOTH  = 2'd2;

    typedef enum logic [2:0] {
        ROLE_PAY  = 3'd0,
        ROLE_ECC0 = 3'd1,
        ROLE_MARK = 3'd2,
        ROLE_ECC1 = 3'd3,
        ROLE_FREE = 3'd4
    } role_e;

    typedef struct packed {
        role_e            role;
        logic [IDX_W-1:0] idx;
    } slot_t;

    // Map a physical offset to its role and its slot in the logical spare view.
    function automatic slot_t classify(input int off, input int step, input int ecc,
                                       input int main_b, input int mark);
        slot_t s;
        int e0_end;
        int mk_end;
        int p1_end;
        int e1_end;
        e0_end = step + ecc;
        mk_end = main_b + mark;
        p1_end = 2 * step + ecc + mark;
        e1_end = p1_end + ecc;
        s.role = ROLE_PAY;
        s.idx  = '0;
        if (off < step) begin
            s.role = ROLE_PAY;
        end else if (off < e0_end) begin
            s.role = ROLE_ECC0;
            s.idx  = IDX_W'(mark + off - step);
        end else if (off < main_b) begin
            s.role = ROLE_PAY;
        end else if (off < mk_end) begin
            s.role = ROLE_MARK;
            s.idx  = IDX_W'(off - main_b);
        end else if (off < p1_end) begin
            s.role = ROLE_PAY;
        end else if (off < e1_end) begin
            s.role = ROLE_ECC1;
            s.idx  = IDX_W'(mark + ecc + off - p1_end);
        end else begin
            s.role = ROLE_FREE;
            s.idx  = IDX_W'(mark + 2 * ecc + off - e1_end);
        end
        return s;
    endfunction

endpackage

// File: rtl/sl_xfer_ctl.sv
module sl_xfer_ctl
    import nand_sl_pkg::*;
#(
    parameter int MAIN_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    localparam int TOTAL = MAIN_BYTES + SPARE_BYTES,
    localparam int OFF_W = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic             accept,
    output logic             busy,
    output logic [OFF_W-1:0] off,
    output logic             start_ok,
    output logic             done,
    output logic             partial,
    output logic             err
);
    localparam logic [OFF_W-1:0] SPARE_BASE = OFF_W'(MAIN_BYTES);
    localparam logic [OFF_W-1:0] MAIN_LAST  = OFF_W'(MAIN_BYTES - 1);
    localparam logic [OFF_W-1:0] PAGE_LAST  = OFF_W'(TOTAL - 1);

    logic [1:0]       mode_q;
    logic [OFF_W-1:0] last_off;
    logic             at_last;

    assign start_ok = start && !busy;
    assign last_off = (mode_q == XFER_MAIN) ? MAIN_LAST : PAGE_LAST;
    assign at_last  = (off == last_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            off     <= '0;
            mode_q  <= XFER_BOTH;
            done    <= 1'b0;
            partial <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start_ok) begin
                busy    <= 1'b1;
                mode_q  <= mode;
                off     <= (mode == XFER_SPARE) ? SPARE_BASE : '0;
                err     <= 1'b0;
                partial <= 1'b0;
            end else if (start) begin
                err <= 1'b1;
            end
            if (accept) begin
                off <= off + 1'b1;
                if (at_last) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    partial <= (mode_q == XFER_MAIN) || (mode_q == XFER_SPARE);
                end
            end
        end
    end

    p_err_on_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> err);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_off_in_page_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (off <= PAGE_LAST));

    p_spare_base_r4: assert property (@(posedge clk) disable iff (rst)
        (start_ok && mode == XFER_SPARE) |=> (off == SPARE_BASE));

    p_main_base_r5: assert property (@(posedge clk) disable iff (rst)
        (start_ok && mode == XFER_MAIN) |=> (off == '0 && busy));

endmodule

// File: rtl/sl_role_map.sv
module sl_role_map
    import nand_sl_pkg::*;
#(
    parameter int STEP_BYTES = 1024,
    parameter int ECC_BYTES  = 14,
    parameter int MAIN_BYTES = 2048,
    parameter int MARK_BYTES = 8,
    parameter int OFF_W      = 12
) (
    input  logic [OFF_W-1:0] off,
    output role_e            role,
    output logic [IDX_W-1:0] idx
);
    slot_t s;

    always_comb begin
        s    = classify(int'(off), STEP_BYTES, ECC_BYTES, MAIN_BYTES, MARK_BYTES);
        role = s.role;
        idx  = s.idx;
    end

endmodule

// File: rtl/sl_oob_gather.sv
module sl_oob_gather
    import nand_sl_pkg::*;
#(
    parameter int OOB_BYTES = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    output logic [OOB_BYTES*8-1:0] oob_flat
);
    for (genvar k = 0; k < OOB_BYTES; k++) begin : g_slot
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                byte_q <= 8'h00;
            end else if (wr_en && wr_idx == IDX_W'(k)) begin
                byte_q <= wr_data;
            end
        end
        assign oob_flat[8*k +: 8] = byte_q;
    end

    p_idx_in_view_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < OOB_BYTES));

    p_no_write_on_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clear |-> !wr_en);

endmodule

// File: rtl/nand_syn_deint.sv
module nand_syn_deint
    import nand_sl_pkg::*;
#(
    parameter int STEP_BYTES  = 1024,
    parameter int ECC_BYTES   = 14,
    parameter int MAIN_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int MARK_BYTES  = 8,
    localparam int TOTAL      = MAIN_BYTES + SPARE_BYTES,
    localparam int OFF_W      = $clog2(TOTAL + 1),
    localparam int FREE_BYTES = TOTAL - (2 * STEP_BYTES + 2 * ECC_BYTES + MARK_BYTES),
    localparam int OOB_BYTES  = MARK_BYTES + 2 * ECC_BYTES + FREE_BYTES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [1:0]             xfer_mode,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic                   dout_valid,
    output logic [7:0]             dout_data,
    input  logic                   dout_ready,
    output logic [OOB_BYTES*8-1:0] oob_bytes,
    output logic                   done,
    output logic                   partial,
    output logic                   err
);
    logic             busy;
    logic             start_ok;
    logic             accept;
    logic [OFF_W-1:0] off;
    role_e            role;
    logic [IDX_W-1:0] oob_idx;

    assign in_ready = busy && (!dout_valid || dout_ready);
    assign accept   = in_valid && in_ready;

    sl_xfer_ctl #(
        .MAIN_BYTES (MAIN_BYTES),
        .SPARE_BYTES(SPARE_BYTES)
    ) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mode    (xfer_mode),
        .accept  (accept),
        .busy    (busy),
        .off     (off),
        .start_ok(start_ok),
        .done    (done),
        .partial (partial),
        .err     (err)
    );

    sl_role_map #(
        .STEP_BYTES(STEP_BYTES),
        .ECC_BYTES (ECC_BYTES),
        .MAIN_BYTES(MAIN_BYTES),
        .MARK_BYTES(MARK_BYTES),
        .OFF_W     (OFF_W)
    ) u_map (
        .off (off),
        .role(role),
        .idx (oob_idx)
    );

    sl_oob_gather #(
        .OOB_BYTES(OOB_BYTES)
    ) u_oob (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_ok),
        .wr_en   (accept && role != ROLE_PAY),
        .wr_idx  (oob_idx),
        .wr_data (in_data),
        .oob_flat(oob_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_valid <= 1'b0;
            dout_data  <= 8'h00;
        end else if (accept && role == ROLE_PAY) begin
            dout_valid <= 1'b1;
            dout_data  <= in_data;
        end else if (dout_ready) begin
            dout_valid <= 1'b0;
        end
    end

    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

    p_no_payload_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !dout_valid) |=> !dout_valid);

    p_stall_blocks_input_r8: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && !dout_ready) |-> !in_ready);

endmodule

// File: tb/test_nand_syn_deint.sv
module test_nand_syn_deint;
    localparam int ST  = 32;
    localparam int EC  = 4;
    localparam int MN  = 64;
    localparam int SP  = 16;
    localparam int MK  = 2;
    localparam int TOT = MN + SP;
    localparam int OOB = MK + 2 * EC + (TOT - (2 * ST + 2 * EC + MK));

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [1:0]      xfer_mode = 2'd2;
    logic            in_valid = 1'b0;
    logic [7:0]      in_data = 8'h00;
    logic            in_ready;
    logic            dout_valid;
    logic [7:0]      dout_data;
    logic            dout_ready = 1'b1;
    logic [OOB*8-1:0] oob_bytes;
    logic            done;
    logic            partial;
    logic            err;

    always #10 clk = ~clk;

    nand_syn_deint #(
        .STEP_BYTES(ST), .ECC_BYTES(EC), .MAIN_BYTES(MN),
        .SPARE_BYTES(SP), .MARK_BYTES(MK)
    ) i_nand_syn_deint (
        .clk(clk), .rst(rst), .start(start), .xfer_mode(xfer_mode),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .dout_valid(dout_valid), .dout_data(dout_data), .dout_ready(dout_ready),
        .oob_bytes(oob_bytes), .done(done), .partial(partial), .err(err)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Slot in the logical spare view, or -1 for payload (R2, R3).
    function automatic int view_slot(input int off);
        if (off < ST) return -1;
        if (off < ST + EC) return MK + (off - ST);
        if (off < MN) return -1;
        if (off < MN + MK) return off - MN;
        if (off < 2 * ST + EC + MK) return -1;
        if (off < 2 * ST + 2 * EC + MK) return MK + EC + (off - (2 * ST + EC + MK));
        return MK + 2 * EC + (off - (2 * ST + 2 * EC + MK));
    endfunction

    function automatic logic [7:0] pat(input int off, input int seed);
        return 8'((off * 37 + seed * 11 + 5) & 255);
    endfunction

    // Reference model state
    logic [7:0] exp_q[$];
    logic [7:0] exp_oob[OOB];
    bit m_busy = 0, m_done = 0, m_err = 0, m_partial = 0, mon_en = 0;
    int m_off = 0, m_last = 0, m_mode = 0, cyc = 0;

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
        if (mon_en) begin
            bit was_busy;
            was_busy = m_busy;
            chk(in_ready == (m_busy && (!dout_valid || dout_ready)), "R8 in_ready",
                int'(in_ready), int'(m_busy && (!dout_valid || dout_ready)));
            chk(dout_valid == (exp_q.size() != 0), "R2 dout_valid",
                int'(dout_valid), int'(exp_q.size() != 0));
            chk(done == m_done, "R6 done", int'(done), int'(m_done));
            chk(err == m_err, "R7 err", int'(err), int'(m_err));
            chk(partial == m_partial, "R10 partial", int'(partial), int'(m_partial));
            m_done = 0;
            if (dout_valid && dout_ready && exp_q.size() != 0) begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(dout_data == e, "R2 dout_data order", int'(dout_data), int'(e));
            end
            if (in_valid && in_ready) begin
                int s;
                s = view_slot(m_off);
                if (s < 0) exp_q.push_back(in_data);
                else exp_oob[s] = in_data;
                if (m_off == m_last) begin
                    m_busy = 0;
                    m_done = 1;
                    m_partial = (m_mode == 0 || m_mode == 1);
                end
                m_off++;
            end
            if (start) begin
                if (!was_busy) begin
                    m_busy = 1;
                    m_mode = int'(xfer_mode);
                    m_off = (xfer_mode == 2'd1) ? MN : 0;
                    m_last = (xfer_mode == 2'd0) ? MN - 1 : TOT - 1;
                    m_err = 0;
                    m_partial = 0;
                    foreach (exp_oob[k]) exp_oob[k] = 8'h00;
                end else begin
                    m_err = 1;
                end
            end
        end
    end

    task automatic check_oob(input string req);
        for (int k = 0; k < OOB; k++)
            chk(oob_bytes[8*k +: 8] == exp_oob[k], req,
                int'(oob_bytes[8*k +: 8]), int'(exp_oob[k]));
    endtask

    // stall: 0 none, 1 random, 2 long hold at the beginning
    task automatic run_page(input logic [1:0] m, input int seed, input int stall,
                            input int err_at, input string req);
        int base, n, i, t;
        bit hs, err_fired;
        base = (m == 2'd1) ? MN : 0;
        n = (m == 2'd0) ? MN : ((m == 2'd1) ? SP : TOT);
        @(posedge clk); #1;
        start = 1'b1; xfer_mode = m;
        @(posedge clk); #1;
        start = 1'b0;
        // R9: buffer is cleared by the accepted start
        for (int k = 0; k < OOB; k++)
            chk(oob_bytes[8*k +: 8] == 8'h00, "R9 oob cleared", int'(oob_bytes[8*k +: 8]), 0);
        i = 0; t = 0; err_fired = 0;
        in_valid = 1'b1; in_data = pat(base, seed);
        while (i < n) begin
            @(negedge clk);
            hs = in_valid && in_ready;
            @(posedge clk); #1;
            t++;
            if (hs) i++;
            start = 1'b0;
            if (err_at >= 0 && i == err_at && !err_fired) begin
                start = 1'b1;
                xfer_mode = 2'd1;
                err_fired = 1;
            end
            if (i < n) in_data = pat(base + i, seed);
            else in_valid = 1'b0;
            case (stall)
                1: dout_ready = ($urandom % 3) != 0;
                2: dout_ready = (t > 40);
                default: dout_ready = 1'b1;
            endcase
        end
        start = 1'b0;
        dout_ready = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check_oob(req);
        chk(exp_q.size() == 0, "R2 payload drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
        chk(dout_valid == 1'b0, "R1 dout_valid", int'(dout_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(err == 1'b0, "R1 err", int'(err), 0);
        chk(partial == 1'b0, "R1 partial", int'(partial), 0);
        chk(oob_bytes == '0, "R1 oob", 0, 0);
        mon_en = 1;
        run_page(2'd2, 1, 0, -1, "R3 both mode view");
        chk(partial == 1'b0, "R10 full page", int'(partial), 0);
        run_page(2'd2, 2, 1, -1, "R3 both mode random stall");
        run_page(2'd1, 3, 0, -1, "R4 spare mode view");
        chk(partial == 1'b1, "R10 spare partial", int'(partial), 1);
        run_page(2'd0, 4, 1, -1, "R5 main mode view");
        chk(partial == 1'b1, "R10 main partial", int'(partial), 1);
        run_page(2'd3, 5, 2, -1, "R11 mode 3 long stall");
        run_page(2'd2, 6, 0, 20, "R7 start ignored mid page");
        chk(err == 1'b1, "R7 err sticky", int'(err), 1);
        run_page(2'd0, 7, 0, MN - 1, "R7 start on last byte");
        run_page(2'd2, 8, 1, -1, "R7 err cleared by start");
        chk(err == 1'b0, "R7 err cleared", int'(err), 0);
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule